// File: doc/BRIEF.md
# Subcarrier Response Envelope Encoder

This block turns a stream of response bytes into the one-bit transmit envelope that a vicinity card sends back to a reader. It runs on the carrier clock, so one clock cycle is one carrier period. Two keying schemes are available. In amplitude keying, a single subcarrier at carrier/32 is switched on or off. In frequency keying, the envelope moves between a carrier/32 subcarrier and a carrier/28 subcarrier. In both schemes every data bit is a two-half cell whose halves swap order with the bit value. Each frame opens with a start symbol and closes with an end symbol, and both symbols are asymmetric.

A frame starts when `start` is raised while the block is idle. The keying mode and the rate code are captured at that moment. The block pulls bytes through a valid/ready handshake at each byte boundary and sends each byte least significant bit first. When no byte is offered at a boundary, it sends the end symbol, drops `busy` and pulses `done`. Every envelope segment is a whole number of subcarrier pulses, and each segment begins at the start of a pulse. A change of subcarrier therefore never cuts a pulse short.

Top module: `subcarrier_resp_encoder`

## Requirements
- R1: With `modeSel`=0 (amplitude keying), bit 0 is a subcarrier half followed by a silent half, and bit 1 is a silent half followed by a subcarrier half. Each half is H carrier/32 pulses, where H is 32, 8, 4, 2 and 1 for `rateSel` codes 0, 1, 2, 3 and 4. Codes 5 to 7 behave like code 4.
- R2: A carrier/32 pulse is 16 cycles with `txEnv` high followed by 16 cycles low. A carrier/28 pulse is 14 high followed by 14 low. A silent segment keeps `txEnv` low. Every segment holds only whole pulses and starts with the high part of a pulse.
- R3: With `modeSel`=1 (frequency keying), bit 0 is 8 carrier/32 pulses followed by 9 carrier/28 pulses, and bit 1 is the same two parts in the opposite order. At `rateSel`=0 the counts are 32 and 36. Every other rate code uses 8 and 9.
- R4: The amplitude-keyed start symbol is a silent stretch of 3H pulse times, then 3H carrier/32 pulses, then a bit 1. The end symbol is a bit 0, then 3H carrier/32 pulses, then a silent stretch of 3H pulse times.
- R5: The frequency-keyed start symbol is 27 carrier/28 pulses, then 24 carrier/32 pulses, then a bit 1. At rate code 0 the counts are 108 and 96. The end symbol is a bit 0, then the carrier/32 stretch, then the carrier/28 stretch.
- R6: `byteReady` is high for exactly one cycle at each byte boundary, which is the last cycle of the start symbol or of a byte's last bit. A byte is taken when `byteValid` and `byteReady` are high together, and its bits go out LSB first. If `byteValid` is low at a boundary, the end symbol follows, so a frame with no data bytes is possible.
- R7: A high `start` sampled while idle begins a frame, and the first envelope cycle is the cycle after that edge. `modeSel` and `rateSel` are captured at that edge. While `busy` is high, changes on `start`, `modeSel` and `rateSel` have no effect.
- R8: `busy` is high from the first envelope cycle through the last cycle of the end symbol. `done` is high for the one cycle that follows. `txEnv` is low whenever `busy` is low.
- R9: While `rstN` is low and right after it is released, `busy`, `done`, `byteReady` and `txEnv` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock, one cycle per carrier period |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame when idle |
| modeSel | input | 1 | 0 = amplitude keying, 1 = frequency keying |
| rateSel | input | 3 | Rate code, 0 = slowest |
| byteData | input | 8 | Next response byte |
| byteValid | input | 1 | `byteData` holds a byte |
| byteReady | output | 1 | Byte boundary, the offered byte is taken |
| txEnv | output | 1 | Transmit envelope |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the end symbol |

## Verification
A wrong segment kind or a wrong pulse count shows at `txEnv` as soon as the wrong segment begins. A swapped subcarrier is visible within 14 cycles, because carrier/28 goes low at cycle 14 where carrier/32 is still high. A count that is too short or too long misaligns the very next segment boundary. A sequencer that loses its place in the start symbol, the bit order or the end symbol changes the order of long and short stretches or sends a byte's bits in the wrong order. This is caught on the first half-bit that differs. A fault in the frame boundary logic appears as a missing or extra `byteReady`, a wrong count of bytes taken, or `done` arriving one cycle off.

// File: rtl/rspenc_pkg.sv
package rspenc_pkg;

  localparam int PULSE_W = 8;

  typedef enum logic [1:0] {
    SEG_QUIET = 2'd0,
    SEG_SLOW  = 2'd1,
    SEG_FAST  = 2'd2
  } segKind_e;

  typedef struct packed {
    logic                 load;
    logic                 stop;
    segKind_e             kind;
    logic [PULSE_W-1:0]   pulses;
  } segCmd_t;

endpackage

// File: rtl/rspenc_subcarrier.sv
module rspenc_subcarrier
  import rspenc_pkg::*;
#(
  parameter int SLOW_HALF = 16,
  parameter int FAST_HALF = 14
) (
  input  logic    clk,
  input  logic    rstN,
  input  segCmd_t cmd,
  output logic    segLast,
  output logic    txEnv
);

  localparam int HALF_MAX = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CNT_W    = $clog2(HALF_MAX);

  logic               active;
  segKind_e           kind;
  logic [CNT_W-1:0]   halfCnt;
  logic [CNT_W-1:0]   halfLim;
  logic               phase;
  logic [PULSE_W-1:0] pulseCnt;
  logic [PULSE_W-1:0] pulseLim;
  logic               halfHit;
  logic               pulseHit;

  always_comb begin
    if (kind == SEG_FAST) halfLim = CNT_W'(FAST_HALF - 1);
    else                  halfLim = CNT_W'(SLOW_HALF - 1);
  end

  assign halfHit  = (halfCnt == halfLim);
  assign pulseHit = (pulseCnt == pulseLim);
  assign segLast  = active && halfHit && phase && pulseHit;
  assign txEnv    = active && (kind != SEG_QUIET) && !phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      kind     <= SEG_QUIET;
      halfCnt  <= '0;
      phase    <= 1'b0;
      pulseCnt <= '0;
      pulseLim <= '0;
    end else if (cmd.load) begin
      active   <= 1'b1;
      kind     <= cmd.kind;
      pulseLim <= cmd.pulses - 1'b1;
      halfCnt  <= '0;
      phase    <= 1'b0;
      pulseCnt <= '0;
    end else if (cmd.stop) begin
      active   <= 1'b0;
      halfCnt  <= '0;
      phase    <= 1'b0;
      pulseCnt <= '0;
    end else if (active) begin
      if (halfHit) begin
        halfCnt <= '0;
        phase   <= ~phase;
        if (phase) pulseCnt <= pulseCnt + 1'b1;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && active) |-> segLast);  // R2
  AST_STOP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stop |-> segLast);  // R8
  AST_PULSE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (pulseCnt <= pulseLim));  // R2

endmodule

// File: rtl/rspenc_sequencer.sv
module rspenc_sequencer
  import rspenc_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int RATE_W        = 3,
  parameter int NUM_RATES     = 5,
  parameter int ASK_LOW_HALF  = 32,
  parameter int ASK_HIGH_HALF = 8,
  parameter int LONG_MULT     = 3,
  parameter int FSK_SLOW_LO   = 32,
  parameter int FSK_FAST_LO   = 36,
  parameter int FSK_SLOW_HI   = 8,
  parameter int FSK_FAST_HI   = 9,
  parameter int LONG_SLOW_LO  = 96,
  parameter int LONG_FAST_LO  = 108,
  parameter int LONG_SLOW_HI  = 24,
  parameter int LONG_FAST_HI  = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeSel,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteValid,
  input  logic              segLast,
  output segCmd_t           cmd,
  output logic              byteReady,
  output logic              busy,
  output logic              done
);

  localparam int RIDX_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SOF, ST_DATA, ST_EOF} frameState_e;

  logic [PULSE_W-1:0] askHalf [NUM_RATES];

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
    if (r == 0) begin : g_low
      assign askHalf[r] = PULSE_W'(ASK_LOW_HALF);
    end else begin : g_fast
      assign askHalf[r] = PULSE_W'(ASK_HIGH_HALF >> (r - 1));
    end
  end

  frameState_e        state, nState;
  logic [1:0]         idx, nIdx;
  logic [BIT_W-1:0]   bitIdx, nBitIdx, nextBit;
  logic [DATA_W-1:0]  shReg;
  logic               modeL;
  logic [RIDX_W-1:0]  rateL, rateIn, effRate;
  logic               effMode;
  logic               nBitVal, atBoundary, fin, advance, take;

  assign rateIn  = (rateSel >= RATE_W'(NUM_RATES)) ? RIDX_W'(NUM_RATES - 1)
                                                  : rateSel[RIDX_W-1:0];
  assign effMode = (state == ST_IDLE) ? modeSel : modeL;
  assign effRate = (state == ST_IDLE) ? rateIn  : rateL;
  assign nextBit = bitIdx + 1'b1;
  assign busy    = (state != ST_IDLE);
  assign advance = (state == ST_IDLE) ? start : segLast;

  // next position in the frame
  always_comb begin
    nState     = state;
    nIdx       = idx;
    nBitIdx    = bitIdx;
    nBitVal    = 1'b0;
    atBoundary = 1'b0;
    fin        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        nState = ST_SOF;
        nIdx   = 2'd0;
      end
      ST_SOF: begin
        if (idx != 2'd3) nIdx = idx + 2'd1;
        else             atBoundary = 1'b1;
      end
      ST_DATA: begin
        if (!idx[0]) begin
          nIdx    = 2'd1;
          nBitVal = shReg[bitIdx];
        end else if (bitIdx != BIT_LAST) begin
          nIdx    = 2'd0;
          nBitIdx = nextBit;
          nBitVal = shReg[nextBit];
        end else begin
          atBoundary = 1'b1;
        end
      end
      ST_EOF: begin
        if (idx != 2'd3) begin
          nIdx = idx + 2'd1;
        end else begin
          fin    = 1'b1;
          nState = ST_IDLE;
          nIdx   = 2'd0;
        end
      end
      default: nState = ST_IDLE;
    endcase
    if (atBoundary) begin
      nIdx    = 2'd0;
      nBitIdx = '0;
      if (byteValid) begin
        nState  = ST_DATA;
        nBitVal = byteData[0];
      end else begin
        nState  = ST_EOF;
      end
    end
  end

  // segment selection for the next position
  logic               longSeg, longSlow, cellBit, cellHalf, cellOn, lowSpd;
  logic [PULSE_W-1:0] halfP;

  always_comb begin
    halfP    = askHalf[effRate];
    lowSpd   = (effRate == '0);
    longSeg  = 1'b0;
    longSlow = 1'b0;
    cellBit  = 1'b0;
    cellHalf = nIdx[0];
    unique case (nState)
      ST_SOF: begin
        if (!nIdx[1]) begin
          longSeg  = 1'b1;
          longSlow = nIdx[0];
        end else begin
          cellBit = 1'b1;
        end
      end
      ST_EOF: begin
        if (nIdx[1]) begin
          longSeg  = 1'b1;
          longSlow = ~nIdx[0];
        end
      end
      default: cellBit = nBitVal;
    endcase
    cellOn = ~(cellHalf ^ cellBit);

    cmd.kind   = SEG_QUIET;
    cmd.pulses = halfP;
    if (!effMode) begin
      if (longSeg) begin
        cmd.kind   = longSlow ? SEG_SLOW : SEG_QUIET;
        cmd.pulses = PULSE_W'(LONG_MULT) * halfP;
      end else begin
        cmd.kind   = cellOn ? SEG_SLOW : SEG_QUIET;
        cmd.pulses = halfP;
      end
    end else begin
      if (longSeg) begin
        cmd.kind   = longSlow ? SEG_SLOW : SEG_FAST;
        cmd.pulses = longSlow ? PULSE_W'(lowSpd ? LONG_SLOW_LO : LONG_SLOW_HI)
                              : PULSE_W'(lowSpd ? LONG_FAST_LO : LONG_FAST_HI);
      end else begin
        cmd.kind   = cellOn ? SEG_SLOW : SEG_FAST;
        cmd.pulses = cellOn ? PULSE_W'(lowSpd ? FSK_SLOW_LO : FSK_SLOW_HI)
                            : PULSE_W'(lowSpd ? FSK_FAST_LO : FSK_FAST_HI);
      end
    end
    cmd.load = advance && !fin;
    cmd.stop = busy && segLast && fin;
  end

  assign byteReady = busy && segLast && atBoundary;
  assign take      = byteReady && byteValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idx    <= 2'd0;
      bitIdx <= '0;
      shReg  <= '0;
      modeL  <= 1'b0;
      rateL  <= '0;
      done   <= 1'b0;
    end else begin
      done <= cmd.stop;
      if (advance) begin
        state  <= nState;
        idx    <= nIdx;
        bitIdx <= nBitIdx;
      end
      if (state == ST_IDLE && start) begin
        modeL <= modeSel;
        rateL <= rateIn;
      end
      if (take) shReg <= byteData;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R8
  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(modeL) && $stable(rateL)));  // R7
  AST_NO_REWIND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |=> (state != ST_SOF));  // R6
  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> (busy && !done));  // R6

endmodule

// File: rtl/subcarrier_resp_encoder.sv
module subcarrier_resp_encoder
  import rspenc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RATE_W    = 3,
  parameter int NUM_RATES = 5,
  parameter int SLOW_HALF = 16,
  parameter int FAST_HALF = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeSel,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteValid,
  output logic              byteReady,
  output logic              txEnv,
  output logic              busy,
  output logic              done
);

  segCmd_t segCmd;
  logic    segLast;

  rspenc_sequencer #(
    .DATA_W    (DATA_W),
    .RATE_W    (RATE_W),
    .NUM_RATES (NUM_RATES)
  ) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .modeSel   (modeSel),
    .rateSel   (rateSel),
    .byteData  (byteData),
    .byteValid (byteValid),
    .segLast   (segLast),
    .cmd       (segCmd),
    .byteReady (byteReady),
    .busy      (busy),
    .done      (done)
  );

  rspenc_subcarrier #(
    .SLOW_HALF (SLOW_HALF),
    .FAST_HALF (FAST_HALF)
  ) u_sub (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (segCmd),
    .segLast (segLast),
    .txEnv   (txEnv)
  );

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !txEnv);  // R8

endmodule

// File: tb/tb_subcarrier_resp_encoder.sv
`timescale 1ns/1ps
module tb_subcarrier_resp_encoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       modeSel = 1'b0;
  logic [2:0] rateSel = 3'd0;
  logic [7:0] byteData = 8'd0;
  logic       byteValid = 1'b0;
  logic       byteReady, txEnv, busy, done;

  subcarrier_resp_encoder dut (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel), .rateSel(rateSel),
    .byteData(byteData), .byteValid(byteValid), .byteReady(byteReady),
    .txEnv(txEnv), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int consumed = 0;
  int framesDone = 0;

  typedef struct { int kind; int pulses; string tag; } seg_t;  // kind 0 silent, 1 fc/32, 2 fc/28, 3 end
  seg_t expQ[$];
  logic [7:0] byteQ[$];
  logic [7:0] bq[$];
  bit pend = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int askH(input int rate);
    int r = (rate > 4) ? 4 : rate;
    return (r == 0) ? 32 : (8 >> (r - 1));
  endfunction

  task automatic pushSeg(input int kind, input int pulses, input string tag);
    seg_t s;
    s.kind = kind; s.pulses = pulses; s.tag = tag;
    expQ.push_back(s);
  endtask

  task automatic pushBit(input int mode, input int rate, input bit b, input string tag);
    int h = askH(rate);
    int ns = (rate == 0) ? 32 : 8;
    int nf = (rate == 0) ? 36 : 9;
    if (mode == 0) begin
      if (!b) begin pushSeg(1, h, tag); pushSeg(0, h, tag); end
      else    begin pushSeg(0, h, tag); pushSeg(1, h, tag); end
    end else begin
      if (!b) begin pushSeg(1, ns, tag); pushSeg(2, nf, tag); end
      else    begin pushSeg(2, nf, tag); pushSeg(1, ns, tag); end
    end
  endtask

  task automatic pushFrame(input int mode, input int rate, input string dataTag);
    int h = askH(rate);
    int ls = (rate == 0) ? 96 : 24;
    int lf = (rate == 0) ? 108 : 27;
    string ft = (mode == 0) ? "R4" : "R5";
    if (mode == 0) begin pushSeg(0, 3*h, ft); pushSeg(1, 3*h, ft); end
    else           begin pushSeg(2, lf, ft);  pushSeg(1, ls, ft);  end
    pushBit(mode, rate, 1'b1, ft);
    foreach (bq[i]) begin
      for (int k = 0; k < 8; k++) pushBit(mode, rate, bq[i][k], dataTag);  // R6 LSB first
    end
    pushBit(mode, rate, 1'b0, ft);
    if (mode == 0) begin pushSeg(1, 3*h, ft); pushSeg(0, 3*h, ft); end
    else           begin pushSeg(1, ls, ft);  pushSeg(2, lf, ft);  end
    pushSeg(3, 0, "R8");
  endtask

  task automatic runFrame(input int mode, input int rate, input string dataTag, input bit disturb);
    int base = consumed;
    int fd = framesDone;
    int nb = bq.size();
    pushFrame(mode, rate, dataTag);
    foreach (bq[i]) byteQ.push_back(bq[i]);
    @(negedge clk);
    modeSel = mode[0];
    rateSel = rate[2:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (300) @(negedge clk);
      modeSel = ~modeSel;   // R7 ignored while busy
      rateSel = 3'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (framesDone != fd);
    check(consumed - base == nb, "R6", "bytes taken", consumed - base, nb);
    repeat (20) begin
      @(negedge clk);
      check(!txEnv && !busy && !byteReady, "R8", "idle silent", int'(txEnv), 0);
    end
  endtask

  // byte feeder
  initial begin
    forever begin
      @(negedge clk);
      if (pend) begin
        void'(byteQ.pop_front());
        consumed++;
      end
      byteValid = (byteQ.size() > 0);
      byteData  = (byteQ.size() > 0) ? byteQ[0] : 8'h00;
      pend = byteValid && byteReady;
    end
  end

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (start && rstN) begin
        forever begin
          seg_t s;
          int p, firstBad, actV, expV;
          bit ok;
          s = expQ.pop_front();
          if (s.kind == 3) break;
          p = (s.kind == 2) ? 28 : 32;
          ok = 1'b1; firstBad = -1; actV = 0; expV = 0;
          for (int c = 0; c < s.pulses * p; c++) begin
            bit e;
            @(negedge clk);
            e = (s.kind == 0) ? 1'b0 : ((c % p) < (p / 2));
            if ((txEnv !== e || busy !== 1'b1) && ok) begin
              ok = 1'b0; firstBad = c; actV = int'(txEnv); expV = int'(e);
            end
          end
          check(ok, s.tag, $sformatf("segment kind=%0d pulses=%0d env at cycle %0d", s.kind, s.pulses, firstBad), actV, expV);
        end
        @(negedge clk);
        check(done === 1'b1 && busy === 1'b0 && txEnv === 1'b0, "R8", "done after end symbol", int'(done), 1);
        @(negedge clk);
        check(done === 1'b0, "R8", "done single cycle", int'(done), 0);
        framesDone++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !byteReady && !txEnv, "R9", "state in reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !byteReady && !txEnv, "R9", "state after reset", int'(txEnv), 0);

    bq = {8'hA5, 8'h3C};        runFrame(0, 1, "R1", 1'b0);
    bq = {8'h00, 8'hFF, 8'h81}; runFrame(0, 4, "R2", 1'b0);
    bq = {8'h96};               runFrame(0, 7, "R1", 1'b0);
    bq = {8'h6E};               runFrame(0, 0, "R1", 1'b0);
    bq = {8'hC3, 8'h01};        runFrame(1, 1, "R3", 1'b0);
    bq = {8'h5A};               runFrame(1, 0, "R3", 1'b0);
    bq = {8'h80};               runFrame(1, 3, "R3", 1'b0);
    bq.delete();                runFrame(0, 2, "R6", 1'b0);
    bq.delete();                runFrame(1, 1, "R6", 1'b0);
    bq = {8'h12};               runFrame(0, 3, "R7", 1'b1);
    bq = {8'hE7};               runFrame(1, 2, "R7", 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule